// File: doc/BRIEF.md
# Serial Character Receiver with Line Error Detection

This block turns an asynchronous serial input into characters for a receive queue. A free-running enable pulses sixteen times per bit period, and the line is sampled on those pulses. A falling edge starts a frame. The edge is checked again at the middle of the start bit. Each data bit is then sampled at the middle of its bit period and placed in the character least significant bit first. The character width and the parity mode come from configuration inputs. These inputs are expected to stay stable while a frame is being received.

When the stop bit is sampled, the block writes one entry to the downstream queue. The entry is a single-cycle write strobe together with the data byte and three error flags: parity, framing and break. If the queue reports full at that moment, the character is dropped and a single-cycle overrun pulse is raised instead. An idle output rises once the line has stayed high for four whole character times while the block is hunting for a start bit.

States: `ST_HUNT` (waiting for a low line) goes to `ST_START` on a low sample. `ST_START` goes back to `ST_HUNT` if the line is high at the middle of the start bit, and to `ST_DATA` if it is still low. `ST_DATA` goes to `ST_PARITY` after the last data bit when parity is on, and to `ST_STOP` when it is off. `ST_PARITY` goes to `ST_STOP`. `ST_STOP` goes to `ST_HUNT` when the stop bit is high. When the stop bit is low, `ST_STOP` goes to `ST_WAIT_HIGH`, which returns to `ST_HUNT` once the line is high again.

Top module: `uart_rx_core`

## Requirements
- R1: `cfg_len` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive least significant first, and `wr_data` bits above the selected width read 0.
- R2: With `cfg_par_en`=1, one parity bit follows the data. With `cfg_par_odd`=0 the data bits plus the parity bit must hold an even count of ones; with `cfg_par_odd`=1 they must hold an odd count. A mismatch sets `wr_perr`. With `cfg_par_en`=0 no parity bit is expected and `wr_perr` is 0.
- R3: A low period that ends before the middle of the start bit (8 enable pulses after detection) produces no write and no overrun.
- R4: A low stop bit with data that is not all zero sets `wr_ferr`=1 and `wr_brk`=0, and the data is still stored. The receiver then waits for a high line before it hunts again.
- R5: If the data bits, the parity bit (when enabled) and the stop bit are all low, exactly one entry is written with `wr_data`=0, `wr_brk`=1, `wr_ferr`=1 and `wr_perr`=0. Nothing more is written until the line has returned high.
- R6: If `fifo_full`=1 when the stop bit is sampled, `wr_en` stays low and `overrun` pulses for one cycle. If `fifo_full`=0, `wr_en` pulses for one cycle and `overrun` stays low.
- R7: `idle` rises after the line has been high for 4 character times (16 enable pulses per bit, with start, data, parity and stop bits counted) while hunting. It is 0 during a frame and before that time has elapsed.
- R8: After reset, `wr_en`, `overrun` and `idle` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit |
| rx | input | 1 | Serial line, asynchronous |
| cfg_len | input | 2 | Data width code (0..3 gives 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| fifo_full | input | 1 | Downstream queue cannot accept an entry |
| wr_en | output | 1 | Single-cycle write strobe |
| wr_data | output | 8 | Received character |
| wr_perr | output | 1 | Parity error for this entry |
| wr_ferr | output | 1 | Framing error for this entry |
| wr_brk | output | 1 | Break flag for this entry |
| overrun | output | 1 | Single-cycle pulse when a character is dropped |
| idle | output | 1 | Line has been quiet for 4 character times |

## Verification
Break detection and overflow handling act on the same stop-bit sample, so both can happen in the same cycle. The bench provokes this by holding the line low for many bit times while `fifo_full` is high. It then expects one overrun pulse, no write strobe, and no further events until the line goes high. A second case puts a parity mismatch and a low stop bit in one frame, and expects both flags on the same entry.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_WAIT_HIGH
    } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/rx_fsm.sv
module rx_fsm
    import uart_rx_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_s,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              fifo_full,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_perr,
    output logic              wr_ferr,
    output logic              wr_brk,
    output logic              overrun,
    output logic              hunting
);
    localparam int TW = $clog2(OVS);
    localparam int BW = $clog2(DATA_W);
    localparam logic [TW-1:0] T_MID  = TW'(OVS/2 - 1);
    localparam logic [TW-1:0] T_LAST = TW'(OVS - 1);

    rx_state_e         state, nxt;
    logic [TW-1:0]     tcnt;
    logic [BW-1:0]     bitcnt;
    logic [BW-1:0]     last_idx;
    logic [DATA_W-1:0] shreg;
    logic              pbit;
    logic              full_tick;
    logic              store;
    logic              brk;

    assign last_idx  = BW'(DATA_W - 4) + BW'(cfg_len);
    assign full_tick = tick && (tcnt == T_LAST);
    assign store     = (state == ST_STOP) && full_tick;
    assign brk       = store && !rx_s && (shreg == '0) && !(cfg_par_en && pbit);
    assign hunting   = (state == ST_HUNT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HUNT:      if (tick && !rx_s) nxt = ST_START;
            ST_START:     if (tick && tcnt == T_MID) nxt = rx_s ? ST_HUNT : ST_DATA;
            ST_DATA:      if (full_tick && bitcnt == last_idx)
                              nxt = cfg_par_en ? ST_PARITY : ST_STOP;
            ST_PARITY:    if (full_tick) nxt = ST_STOP;
            ST_STOP:      if (full_tick) nxt = rx_s ? ST_HUNT : ST_WAIT_HIGH;
            ST_WAIT_HIGH: if (rx_s) nxt = ST_HUNT;
            default:      nxt = ST_HUNT;
        endcase
    end

    // bit timing and character assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt   <= '0;
            bitcnt <= '0;
            shreg  <= '0;
            pbit   <= 1'b0;
        end else begin
            if (state != nxt || full_tick) tcnt <= '0;
            else if (tick)                 tcnt <= tcnt + 1'b1;

            if (state == ST_START && nxt == ST_DATA) begin
                bitcnt <= '0;
                shreg  <= '0;
                pbit   <= 1'b0;
            end else if (state == ST_DATA && full_tick) begin
                shreg[bitcnt] <= rx_s;
                bitcnt        <= bitcnt + 1'b1;
            end else if (state == ST_PARITY && full_tick) begin
                pbit <= rx_s;
            end
        end
    end

    // queue-side outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            overrun <= 1'b0;
            wr_data <= '0;
            wr_perr <= 1'b0;
            wr_ferr <= 1'b0;
            wr_brk  <= 1'b0;
        end else begin
            wr_en   <= store && !fifo_full;
            overrun <= store && fifo_full;
            if (store) begin
                wr_data <= brk ? '0 : shreg;
                wr_perr <= cfg_par_en && !brk && (^shreg ^ pbit ^ cfg_par_odd);
                wr_ferr <= !rx_s;
                wr_brk  <= brk;
            end
        end
    end
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
    parameter int OVS        = 16,
    parameter int DATA_W     = 8,
    parameter int IDLE_CHARS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_s,
    input  logic       hunting,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    output logic       idle
);
    localparam int LIM_MAX = IDLE_CHARS * OVS * (DATA_W + 3);
    localparam int CW      = $clog2(LIM_MAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] frame_bits;
    logic [CW-1:0] limit;
    logic          quiet;

    // start + data + optional parity + stop
    assign frame_bits = CW'(DATA_W - 1) + CW'(cfg_len) + CW'(cfg_par_en);
    assign limit      = frame_bits * CW'(IDLE_CHARS * OVS);
    assign quiet      = hunting && rx_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            idle <= 1'b0;
        end else begin
            if (!quiet)                   cnt <= '0;
            else if (tick && cnt < limit) cnt <= cnt + 1'b1;
            idle <= quiet && (cnt >= limit);
        end
    end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
    parameter int OVS         = 16,
    parameter int DATA_W      = 8,
    parameter int IDLE_CHARS  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rx,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              fifo_full,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_perr,
    output logic              wr_ferr,
    output logic              wr_brk,
    output logic              overrun,
    output logic              idle
);
    logic rx_s;
    logic hunting;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rx), .q(rx_s)
    );

    rx_fsm #(.OVS(OVS), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rx_s(rx_s),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .fifo_full(fifo_full), .wr_en(wr_en), .wr_data(wr_data),
        .wr_perr(wr_perr), .wr_ferr(wr_ferr), .wr_brk(wr_brk),
        .overrun(overrun), .hunting(hunting)
    );

    idle_timer #(.OVS(OVS), .DATA_W(DATA_W), .IDLE_CHARS(IDLE_CHARS)) u_idle (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rx_s(rx_s),
        .hunting(hunting), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
        .idle(idle)
    );
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_full,
    input logic              cfg_par_en,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_perr,
    input logic              wr_ferr,
    input logic              wr_brk,
    input logic              overrun,
    input logic              idle
);
    // R6: an overrun pulse only follows a full queue
    assert_overrun_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(fifo_full));

    // R6: no write is issued into a full queue
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$past(fifo_full));

    // R6: the write strobe lasts one cycle
    assert_single_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R5: a break entry carries zero data and a framing error, and no parity error
    assert_break_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_brk) |-> (wr_ferr && !wr_perr && wr_data == '0));

    // R2: no parity error when parity is off
    assert_no_perr_without_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cfg_par_en) |-> !wr_perr);

    // R7: idle is never reported together with a fresh character
    assert_idle_low_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !idle);
endmodule

bind uart_rx_core uart_rx_core_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_uart_rx_core.sv
module sim_uart_rx_core;
    localparam int BITCLK = 32; // 16 enable pulses, one every 2 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       fifo_full = 1'b0;
    logic       wr_en, wr_perr, wr_ferr, wr_brk, overrun, idle;
    logic [7:0] wr_data;

    int checks = 0;
    int fails = 0;
    int nwr = 0;
    int novr = 0;
    logic [7:0] l_data;
    logic l_perr, l_ferr, l_brk;

    always #4 clk = ~clk;

    always @(posedge clk) tick16 <= rst_n ? ~tick16 : 1'b0;

    uart_rx_core u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx(rx),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .fifo_full(fifo_full), .wr_en(wr_en), .wr_data(wr_data),
        .wr_perr(wr_perr), .wr_ferr(wr_ferr), .wr_brk(wr_brk),
        .overrun(overrun), .idle(idle)
    );

    always @(negedge clk) begin
        if (wr_en) begin
            nwr    <= nwr + 1;
            l_data <= wr_data;
            l_perr <= wr_perr;
            l_ferr <= wr_ferr;
            l_brk  <= wr_brk;
        end
        if (overrun) novr <= novr + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bits_for(input int n);
        repeat (n * BITCLK) @(negedge clk);
    endtask

    // drive one frame, then a two-bit high gap
    task automatic send(input logic [7:0] d, input int nb, input bit pen,
                        input bit pv, input bit stopv);
        rx = 1'b0; bits_for(1);
        for (int i = 0; i < nb; i++) begin rx = d[i]; bits_for(1); end
        if (pen) begin rx = pv; bits_for(1); end
        rx = stopv; bits_for(1);
        rx = 1'b1; bits_for(2);
    endtask

    task automatic expect_entry(input string req, input int w0, input logic [7:0] d,
                                input bit pe, input bit fe, input bit bk);
        chk(nwr == w0 + 1, req, nwr - w0, 1);
        chk(l_data == d, req, l_data, d);
        chk({l_perr, l_ferr, l_brk} == {pe, fe, bk}, req, {l_perr, l_ferr, l_brk}, {pe, fe, bk});
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!wr_en && !overrun && !idle, "R8", {wr_en, overrun, idle}, 0);
    endtask

    task automatic t_lengths;
        int w0;
        cfg_par_en = 0; cfg_len = 2'd3; w0 = nwr;
        send(8'hA5, 8, 0, 0, 1); expect_entry("R1 8N1", w0, 8'hA5, 0, 0, 0);
        cfg_len = 2'd0; w0 = nwr;
        send(8'hFF, 5, 0, 0, 1); expect_entry("R1 5-bit", w0, 8'h1F, 0, 0, 0);
        cfg_len = 2'd1; w0 = nwr;
        send(8'h2D, 6, 0, 0, 1); expect_entry("R1 6-bit", w0, 8'h2D, 0, 0, 0);
    endtask

    task automatic t_parity;
        int w0;
        cfg_par_en = 1; cfg_par_odd = 0; cfg_len = 2'd0; w0 = nwr;
        send(8'h15, 5, 1, 1, 1); expect_entry("R2 even ok", w0, 8'h15, 0, 0, 0);
        w0 = nwr;
        send(8'h15, 5, 1, 0, 1); expect_entry("R2 even bad", w0, 8'h15, 1, 0, 0);
        cfg_par_odd = 1; cfg_len = 2'd2; w0 = nwr;
        send(8'h5A, 7, 1, 1, 1); expect_entry("R2 odd ok", w0, 8'h5A, 0, 0, 0);
        w0 = nwr;
        send(8'h5A, 7, 1, 0, 0); expect_entry("R2 R4 odd bad+frame", w0, 8'h5A, 1, 1, 0);
        cfg_par_en = 0; cfg_par_odd = 0; cfg_len = 2'd3;
    endtask

    task automatic t_false_start;
        int w0, o0;
        w0 = nwr; o0 = novr;
        rx = 1'b0; repeat (10) @(negedge clk);
        rx = 1'b1; bits_for(12);
        chk(nwr == w0 && novr == o0, "R3 glitch", nwr - w0, 0);
        w0 = nwr;
        send(8'h3C, 8, 0, 0, 1); expect_entry("R3 next frame", w0, 8'h3C, 0, 0, 0);
    endtask

    task automatic t_framing;
        int w0;
        w0 = nwr;
        send(8'h81, 8, 0, 0, 0); expect_entry("R4", w0, 8'h81, 0, 1, 0);
    endtask

    task automatic t_break;
        int w0;
        w0 = nwr;
        rx = 1'b0; bits_for(30);
        chk(nwr == w0 + 1, "R5 one entry while low", nwr - w0, 1);
        rx = 1'b1; bits_for(2);
        expect_entry("R5 break", w0, 8'h00, 0, 1, 1);
        w0 = nwr;
        send(8'h42, 8, 0, 0, 1); expect_entry("R5 resume", w0, 8'h42, 0, 0, 0);
    endtask

    task automatic t_overflow;
        int w0, o0;
        fifo_full = 1; w0 = nwr; o0 = novr;
        send(8'h77, 8, 0, 0, 1);
        chk(nwr == w0, "R6 no write when full", nwr - w0, 0);
        chk(novr == o0 + 1, "R6 overrun pulse", novr - o0, 1);
        o0 = novr;
        rx = 1'b0; bits_for(25); rx = 1'b1; bits_for(2);
        chk(nwr == w0, "R6 R5 break dropped", nwr - w0, 0);
        chk(novr == o0 + 1, "R6 R5 break overrun", novr - o0, 1);
        fifo_full = 0; o0 = novr;
        send(8'h11, 8, 0, 0, 1); expect_entry("R6 after full", w0, 8'h11, 0, 0, 0);
        chk(novr == o0, "R6 no overrun", novr - o0, 0);
    endtask

    task automatic t_idle;
        cfg_len = 2'd3; cfg_par_en = 0;
        send(8'h00, 8, 0, 0, 1);
        chk(idle == 0, "R7 busy after frame", idle, 0);
        repeat (1000) @(negedge clk);
        chk(idle == 0, "R7 before threshold", idle, 0);
        repeat (400) @(negedge clk);
        chk(idle == 1, "R7 after threshold", idle, 1);
        rx = 1'b0; repeat (8) @(negedge clk);
        chk(idle == 0, "R7 clears on low", idle, 0);
        rx = 1'b1; bits_for(12);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        bits_for(2);
        t_lengths();
        t_parity();
        t_false_start();
        t_framing();
        t_break();
        t_overflow();
        t_idle();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule